// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block gathers twenty interrupt request lines and forwards one of them at a time to a processor core. Each source has a sticky pending flag, an enable bit and a 3-bit priority level. Among the sources that are both pending and enabled, the one with the highest level is presented. A tie goes to the smallest source number. The presented request is a registered triple: a request flag, a 5-bit vector and a 3-bit level. The core compares the level against its own current interrupt level.

The presented vector and level are re-evaluated every cycle. A stronger request that arrives before the core responds takes over the outputs, and the request it displaced stays pending. When the core pulses the acknowledge line, the pending flag of the presented vector is cleared, and the next winner appears on the following cycle.

Software programs the levels, the enables and the pending flags through a 16-bit memory-mapped register bus with combinational read data. Levels are packed two per register. Pending flags can be cleared by writing ones.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, every level is 0, every enable is 0, no flag is pending, `irq_req` is 0, and every level, enable and pending register reads 0.
- R2: Level register k sits at address 0x4306+2k (k = 0..9). It holds source 2k's level in bits [2:0] and source 2k+1's level in bits [10:8]. All other bits read 0, and writes to them are ignored.
- R3: The enable bits are at 0x4320 (bit i = source i, for sources 0–15) and 0x4322 (bits [3:0] = sources 16–19); unused bits read 0. A pending source whose enable bit is 0 is not presented, and it keeps its pending flag.
- R4: A one-cycle high on `irq_src[i]` sets pending flag i, and the flag stays set. The flags read at 0x4324 and 0x4326, with the same bit layout as the enables. Writing a 1 to a bit clears that flag, and writing a 0 leaves it alone. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R5: Among the pending, enabled sources, the one with the highest level is presented. `irq_lvl` carries that source's programmed level.
- R6: Among pending, enabled sources that share the highest level, the lowest source number is presented.
- R7: The outputs are registered. A request pulse in cycle t shows on the outputs from cycle t+1. `irq_req` is high exactly when some enabled source is pending.
- R8: A higher-priority request that arrives before acknowledge replaces `irq_vec`/`irq_lvl`. The displaced source stays pending and is presented once the stronger one has been acknowledged.
- R9: `irq_ack` high while `irq_req` is high clears the pending flag of the presented vector at that clock edge, and the next winner is presented from the following cycle. `irq_ack` while `irq_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when no register is hit) |
| irq_src | input | 20 | Per-source request pulses |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 5 | Vector number of the presented source |
| irq_lvl | output | 3 | Level of the presented source |
| irq_ack | input | 1 | Core acknowledge of the presented vector |

## Verification
The hardest case to reach is a displaced request: a weaker source must be on the outputs and still unacknowledged when a stronger one arrives. The bench raises the weaker source alone, holds acknowledge low, and then pulses the stronger one. It then acknowledges twice to show that the displaced source comes back. A flag set and a software clear hitting the same edge is equally hard to reach, so the bench drives a write-one-to-clear and a request pulse for the same source in one cycle. An acknowledge with no request presented is shown to be ignored by masking a pending source and then reading back its flag.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NUM_SRC = 20,
  parameter int LVL_W = 3,
  parameter logic [15:0] LVL_BASE = 16'h4306,
  parameter logic [15:0] EN_BASE = 16'h4320,
  parameter logic [15:0] PND_BASE = 16'h4324,
  localparam int VEC_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [15:0]        bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [LVL_W-1:0]   irq_lvl,
  input  logic               irq_ack
);
  localparam int LVL_REGS = (NUM_SRC + 1) / 2;
  localparam int MASK_WORDS = (NUM_SRC + 15) / 16;

  logic [LVL_W-1:0]   lvl_q [NUM_SRC];
  logic [LVL_W-1:0]   lvl_n [NUM_SRC];
  logic [NUM_SRC-1:0] en_q, en_n, pend_q, pend_n;
  logic [15:0]        off_lvl, off_en, off_pnd;
  logic               hit_lvl, hit_en, hit_pnd, take_ack;
  logic               win_any;
  logic [VEC_W-1:0]   win_vec;
  logic [LVL_W-1:0]   win_lvl;

  assign off_lvl  = bus_addr - LVL_BASE;
  assign off_en   = bus_addr - EN_BASE;
  assign off_pnd  = bus_addr - PND_BASE;
  assign hit_lvl  = bus_sel && !off_lvl[0] && (off_lvl[15:1] < 15'(LVL_REGS));
  assign hit_en   = bus_sel && !off_en[0]  && (off_en[15:1]  < 15'(MASK_WORDS));
  assign hit_pnd  = bus_sel && !off_pnd[0] && (off_pnd[15:1] < 15'(MASK_WORDS));
  assign take_ack = irq_ack && irq_req;

  always_comb begin
    en_n   = en_q;
    pend_n = pend_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl_n[i] = lvl_q[i];
      if (hit_lvl && bus_wr && off_lvl[15:1] == 15'(i / 2))
        lvl_n[i] = bus_wdata[(i % 2) * 8 +: LVL_W];
      if (hit_en && bus_wr && off_en[15:1] == 15'(i / 16))
        en_n[i] = bus_wdata[i % 16];
      if (hit_pnd && bus_wr && off_pnd[15:1] == 15'(i / 16) && bus_wdata[i % 16])
        pend_n[i] = 1'b0;
      if (take_ack && irq_vec == VEC_W'(i))
        pend_n[i] = 1'b0;
      if (irq_src[i])
        pend_n[i] = 1'b1;
    end
  end

  always_comb begin
    win_any = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_n[i] && en_n[i] && (!win_any || lvl_n[i] >= win_lvl)) begin
        win_any = 1'b1;
        win_vec = VEC_W'(i);
        win_lvl = lvl_n[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit_lvl && off_lvl[15:1] == 15'(i / 2))
        bus_rdata[(i % 2) * 8 +: LVL_W] = lvl_q[i];
      if (hit_en && off_en[15:1] == 15'(i / 16))
        bus_rdata[i % 16] = en_q[i];
      if (hit_pnd && off_pnd[15:1] == 15'(i / 16))
        bus_rdata[i % 16] = pend_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else begin
      lvl_q   <= lvl_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
      irq_req <= win_any;
      irq_vec <= win_vec;
      irq_lvl <= win_lvl;
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NUM_SRC = 20,
  localparam int VEC_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_src,
  input logic               irq_ack,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_q
);
  p_req_follows_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == |(pend_q & en_q));

  p_vec_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, irq_vec} < (VEC_W + 1)'(NUM_SRC)));

  p_vec_is_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[irq_vec] && en_q[irq_vec]));

  p_pulse_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_src) |=> ((pend_q & $past(irq_src)) == $past(irq_src)));

  p_ack_moves_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !irq_src[irq_vec]) |=> (!irq_req || irq_vec != $past(irq_vec)));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .irq_ack(irq_ack),
  .irq_req(irq_req), .irq_vec(irq_vec), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/irq_level_arbiter_tb_top.sv
module irq_level_arbiter_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] LVL0 = 16'h4306;
  localparam logic [15:0] EN0  = 16'h4320;
  localparam logic [15:0] EN1  = 16'h4322;
  localparam logic [15:0] PND0 = 16'h4324;
  localparam logic [15:0] PND1 = 16'h4326;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [19:0] irq_src = '0;
  logic        irq_req, irq_ack = 0;
  logic [4:0]  irq_vec;
  logic [2:0]  irq_lvl;
  int checks = 0, errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  irq_level_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic expect_read(input string req, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input logic [19:0] m);
    @(posedge clk); #1 irq_src = m;
    @(posedge clk); #1 irq_src = '0;
  endtask

  task automatic ack();
    @(posedge clk); #1 irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
  endtask

  task automatic expect_out(input string req, input logic r, input logic [4:0] v, input logic [2:0] l);
    @(negedge clk);
    check({req, " irq_req"}, irq_req, r);
    if (r) begin
      check({req, " irq_vec"}, irq_vec, v);
      check({req, " irq_lvl"}, irq_lvl, l);
    end
  endtask

  task automatic set_level(input int s, input logic [2:0] l);
    logic [15:0] a, d;
    a = LVL0 + 16'(2 * (s / 2));
    bus_read(a, d);
    d[(s % 2) * 8 +: 3] = l;
    bus_write(a, d);
  endtask

  task automatic clear_levels();
    for (int k = 0; k < 10; k++) bus_write(LVL0 + 16'(2 * k), 16'h0000);
  endtask

  task automatic enable_all(input logic on);
    bus_write(EN0, on ? 16'hFFFF : 16'h0000);
    bus_write(EN1, on ? 16'hFFFF : 16'h0000);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 0);
    expect_read("R1 level reg 0", LVL0, 16'h0000);
    expect_read("R1 level reg 9", LVL0 + 16'd18, 16'h0000);
    expect_read("R1 enable", EN0, 16'h0000);
    expect_read("R1 pending", PND0, 16'h0000);
  endtask

  task automatic t_regmap();
    bus_write(LVL0, 16'hFFFF);
    expect_read("R2 reserved bits read 0", LVL0, 16'h0707);
    bus_write(LVL0 + 16'd18, 16'h0502);
    expect_read("R2 sources 18/19 fields", LVL0 + 16'd18, 16'h0502);
    bus_write(LVL0 + 16'd8, 16'h0A0B);
    expect_read("R2 sources 8/9 fields", LVL0 + 16'd8, 16'h0203);
    clear_levels();
    expect_read("R2 cleared", LVL0, 16'h0000);
  endtask

  task automatic t_enable_mask();
    enable_all(1);
    expect_read("R3 upper enable width", EN1, 16'h000F);
    bus_write(EN0, 16'hFFEF);
    pulse(20'h00010);
    expect_out("R3 masked source hidden", 0, 0, 0);
    expect_read("R3 masked source keeps flag", PND0, 16'h0010);
    bus_write(EN0, 16'hFFFF);
    expect_out("R3 unmasked source shown", 1, 4, 0);
    ack();
    expect_out("R3 cleared", 0, 0, 0);
  endtask

  task automatic t_w1c();
    pulse(20'h20080);
    expect_read("R4 low pending word", PND0, 16'h0080);
    expect_read("R4 high pending word", PND1, 16'h0002);
    bus_write(PND0, 16'h0000);
    expect_read("R4 writing zero keeps flag", PND0, 16'h0080);
    bus_write(PND0, 16'h0080);
    bus_write(PND1, 16'h0002);
    expect_read("R4 W1C low", PND0, 16'h0000);
    expect_read("R4 W1C high", PND1, 16'h0000);
    expect_out("R4 nothing pending", 0, 0, 0);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = PND0; bus_wdata = 16'h0008; irq_src = 20'h8;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; irq_src = '0;
    expect_read("R4 set wins over clear", PND0, 16'h0008);
    bus_write(PND0, 16'h0008);
    expect_out("R4 cleared after race", 0, 0, 0);
  endtask

  task automatic t_highest_level();
    set_level(2, 3'd3);
    set_level(9, 3'd6);
    set_level(15, 3'd1);
    pulse(20'h08204);
    expect_out("R5 highest level first", 1, 9, 6);
    ack();
    expect_out("R5/R9 next winner after ack", 1, 2, 3);
    ack();
    expect_out("R5 lowest level last", 1, 15, 1);
    ack();
    expect_out("R9 all acknowledged", 0, 0, 0);
    clear_levels();
  endtask

  task automatic t_tie();
    set_level(5, 3'd4);
    set_level(12, 3'd4);
    pulse(20'h01020);
    expect_out("R6 tie lowest number", 1, 5, 4);
    ack();
    expect_out("R6 tie second", 1, 12, 4);
    ack();
    pulse(20'h80800);
    expect_out("R6 tie at level 0", 1, 11, 0);
    ack();
    expect_out("R6 tie at level 0 second", 1, 19, 0);
    ack();
    expect_out("R6 done", 0, 0, 0);
    clear_levels();
  endtask

  task automatic t_latency();
    @(posedge clk); #1 irq_src = 20'h1;
    @(negedge clk);
    check("R7 not yet visible in pulse cycle", irq_req, 1'b0);
    @(posedge clk); #1 irq_src = '0;
    expect_out("R7 visible next cycle", 1, 0, 0);
    ack();
    expect_out("R7 drops when nothing pending", 0, 0, 0);
  endtask

  task automatic t_preempt();
    set_level(6, 3'd2);
    set_level(14, 3'd5);
    pulse(20'h00040);
    expect_out("R8 weaker presented", 1, 6, 2);
    pulse(20'h04000);
    expect_out("R8 stronger replaces", 1, 14, 5);
    ack();
    expect_out("R8 displaced returns", 1, 6, 2);
    ack();
    expect_out("R8 done", 0, 0, 0);
    clear_levels();
  endtask

  task automatic t_ack_ignored();
    enable_all(0);
    pulse(20'h00100);
    expect_out("R9 masked, no request", 0, 0, 0);
    ack();
    expect_read("R9 ack without request ignored", PND0, 16'h0100);
    bus_write(PND0, 16'h0100);
    enable_all(1);
    expect_out("R9 clean", 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regmap();
    t_enable_mask();
    t_w1c();
    t_highest_level();
    t_tie();
    t_latency();
    t_preempt();
    t_ack_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule